// File: doc/BRIEF.md
# Real-Time Clock Time-of-Day Counter Chain

This block keeps the time of day as four cascaded counters: a fraction-of-second counter advanced by a 1/128-second tick enable, then seconds, minutes and hours. The tick enable is produced elsewhere from a calibrated 32 kHz time base and arrives here as a one-cycle pulse in the system clock domain. Each counter carries into the next when it passes its upper limit. The hours counter wraps either after 23 or after 255, as chosen by a mode bit. Each hours wrap raises a sticky midnight flag, which drives a pending-interrupt output.

The processor reads and writes the counters and a control register through a small register port. Writes take effect on the next clock edge, and reads are combinational.

Two resets are provided. Power-on reset clears all state. A warm reset, from a watchdog or an external pin, keeps the counters and the hour mode. It only returns the enable bit to 1 and drops the midnight flag.

Top module: `rtc_tod_chain`

## Requirements
- R1: After power-on reset all four counters read 0 and the control register reads 0x01. Control register bits: bit0 is the count enable, bit1 is the 24-hour mode, and bit2 is the midnight flag. Its other bits read 0.
- R2: On each clock with tick_128 high and the enable set, the fraction counter advances by 1. When it is at 127 or above, it goes to 0 and carries into the seconds counter.
- R3: A carry into seconds at 59 or above sends seconds to 0 and carries into minutes. A carry into minutes at 59 or above sends minutes to 0 and carries into hours. Otherwise the receiving counter advances by 1.
- R4: With mode bit 1, a carry into hours at 23 or above sends hours to 0. With mode bit 0, hours wrap from 255 to 0, and 24, for example, advances to 25.
- R5: Every hours wrap sets the midnight flag, and midnight_irq follows it. The flag stays set until a control write with bit2 = 0 clears it. Writing bit2 = 1 never sets it.
- R6: If a control write clears the flag in the same cycle as an hours wrap, the flag ends up set.
- R7: A write to a counter loads wdata on that edge, and the load wins over any increment of that counter in the same cycle.
- R8: While the enable bit is 0, tick_128 changes no counter.
- R9: A warm reset (warm_rst_n low) keeps all counters and the mode bit. It sets the enable bit to 1 and clears the midnight flag.
- R10: Register addresses: 0 is control, 1 is fraction, 2 is seconds, 3 is minutes, 4 is hours. All other addresses read 0. rdata is combinational from addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Synchronous active-low power-on reset; clears everything |
| warm_rst_n | input | 1 | Synchronous active-low warm reset; keeps the time and the mode |
| tick_128 | input | 1 | One-cycle enable pulse, 128 per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| midnight_irq | output | 1 | Pending interrupt, high while the midnight flag is set |

## Verification
The assertions check the local stepping rules on every cycle:
- the fraction and hours wraps;
- the carry from fraction into seconds;
- the priority of loads over increments;
- the counters holding still without an enabled tick;
- the midnight flag staying set, and winning over a same-cycle clear.

Some behaviours only the bench's scenarios show:
- multi-stage rollovers across many ticks;
- the difference between the two hour modes from the same start time;
- warm reset keeping the time while power-on reset erases it;
- a write of bit2 = 1 having no effect on the flag.

// File: rtl/rtc_pkg.sv
// Package: shared constants and the register address map of the time-of-day chain.
// Assumes the 8-bit register view used by the processor port.
package rtc_pkg;
    localparam int STAGES = 4;

    typedef enum logic [2:0] {
        RA_CTRL = 3'd0,
        RA_FRAC = 3'd1,
        RA_SEC  = 3'd2,
        RA_MIN  = 3'd3,
        RA_HOUR = 3'd4
    } rtc_addr_e;

    // Control register bit positions (software-visible encoding)
    localparam int CB_EN   = 0;
    localparam int CB_M24  = 1;
    localparam int CB_FLAG = 2;
endpackage

// File: rtl/rtc_wrap_cnt.sv
// Module: one stage of the counter chain. It advances on inc and returns to 0
// when inc arrives at or above lim. at_top tells the next stage that a carry is due.
// Assumes lim is stable for the cycle. A load wins over the increment.
// Only power-on reset touches the state.
module rtc_wrap_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         inc,
    input  logic [W-1:0] lim,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output logic         at_top
);
    // Compare against the limit; values above it also count as full.
    always_comb at_top = (cnt >= lim);

    // Counter state: power-on clear, load has priority, else wrap or step.
    always_ff @(posedge clk) begin
        if (!por_n)
            cnt <= '0;
        else if (ld)
            cnt <= ld_val;
        else if (inc)
            cnt <= at_top ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/rtc_ctrl_reg.sv
// Module: control register holding the count enable, the 24-hour mode and the
// sticky midnight flag. Assumes the warm reset is synchronous and active low.
// The flag set wins over a software clear.
module rtc_ctrl_reg (
    input  logic       clk,
    input  logic       por_n,
    input  logic       warm_rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic       wrap_evt,
    output logic       en,
    output logic       mode24,
    output logic       flag
);
    import rtc_pkg::*;

    // Enable and mode: power-on sets the defaults, warm reset restores only the enable.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            en     <= 1'b1;
            mode24 <= 1'b0;
        end else if (!warm_rst_n) begin
            en     <= 1'b1;
        end else if (wr) begin
            en     <= wdata[CB_EN];
            mode24 <= wdata[CB_M24];
        end
    end

    // Midnight flag: set by a wrap, cleared by writing 0, the set taking priority.
    always_ff @(posedge clk) begin
        if (!por_n || !warm_rst_n)
            flag <= 1'b0;
        else if (wrap_evt)
            flag <= 1'b1;
        else if (wr && !wdata[CB_FLAG])
            flag <= 1'b0;
    end
endmodule

// File: rtl/rtc_tod_chain.sv
// Module: top of the time-of-day counter chain. It builds four cascaded
// rtc_wrap_cnt stages, the control register and the read mux.
// Assumes tick_128 is a single-cycle pulse in the clk domain.
module rtc_tod_chain #(
    parameter int W        = 8,
    parameter int AW       = 3,
    parameter int FRAC_MAX = 127,
    parameter int SEC_MAX  = 59,
    parameter int MIN_MAX  = 59,
    parameter int HR24_MAX = 23
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          warm_rst_n,
    input  logic          tick_128,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic          midnight_irq
);
    import rtc_pkg::*;

    localparam int HR_FULL = (1 << W) - 1;

    logic [STAGES:0]   carry;
    logic [STAGES-1:0] at_top;
    logic [W-1:0]      cnt [STAGES];
    logic [W-1:0]      lim [STAGES];
    logic              en, mode24, flag;
    logic              wr_ctrl;

    // Control write decode.
    always_comb wr_ctrl = wr_en && (addr == AW'(RA_CTRL));

    // Per-stage wrap limits; the hours limit follows the mode bit.
    always_comb begin
        lim[0] = W'(FRAC_MAX);
        lim[1] = W'(SEC_MAX);
        lim[2] = W'(MIN_MAX);
        lim[3] = mode24 ? W'(HR24_MAX) : W'(HR_FULL);
    end

    // The chain input is an enabled tick.
    assign carry[0] = tick_128 && en;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            rtc_wrap_cnt #(.W(W)) u_cnt (
                .clk    (clk),
                .por_n  (por_n),
                .inc    (carry[g]),
                .lim    (lim[g]),
                .ld     (wr_en && (addr == AW'(g + 1))),
                .ld_val (wdata),
                .cnt    (cnt[g]),
                .at_top (at_top[g])
            );
            assign carry[g+1] = carry[g] && at_top[g];
        end
    endgenerate

    rtc_ctrl_reg u_ctrl (
        .clk        (clk),
        .por_n      (por_n),
        .warm_rst_n (warm_rst_n),
        .wr         (wr_ctrl),
        .wdata      (wdata),
        .wrap_evt   (carry[STAGES]),
        .en         (en),
        .mode24     (mode24),
        .flag       (flag)
    );

    assign midnight_irq = flag;

    // Combinational register read mux.
    always_comb begin
        rdata = '0;
        case (addr)
            AW'(RA_CTRL): begin
                rdata[CB_EN]   = en;
                rdata[CB_M24]  = mode24;
                rdata[CB_FLAG] = flag;
            end
            AW'(RA_FRAC): rdata = cnt[0];
            AW'(RA_SEC):  rdata = cnt[1];
            AW'(RA_MIN):  rdata = cnt[2];
            AW'(RA_HOUR): rdata = cnt[3];
            default:      rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_tod_chain_chk.sv
// Checker: cycle-level properties of the counter chain, attached by bind.
// Assumes the default register map.
module rtc_tod_chain_chk #(
    parameter int W        = 8,
    parameter int AW       = 3,
    parameter int FRAC_MAX = 127,
    parameter int SEC_MAX  = 59,
    parameter int HR24_MAX = 23
) (
    input logic          clk,
    input logic          por_n,
    input logic          warm_rst_n,
    input logic          step,
    input logic          wr_en,
    input logic [AW-1:0] addr,
    input logic [W-1:0]  wdata,
    input logic [W-1:0]  frac,
    input logic [W-1:0]  sec,
    input logic [W-1:0]  min_c,
    input logic [W-1:0]  hour,
    input logic          mode24,
    input logic          irq
);
    logic ld_frac, ld_sec, ld_hour, clr_wr, full_low;
    assign ld_frac  = wr_en && addr == AW'(1);
    assign ld_sec   = wr_en && addr == AW'(2);
    assign ld_hour  = wr_en && addr == AW'(4);
    assign clr_wr   = wr_en && addr == AW'(0) && !wdata[2];
    assign full_low = frac >= W'(FRAC_MAX) && sec >= W'(SEC_MAX) && min_c >= W'(59);

    // R2: the fraction counter wraps to 0
    a_r2_frac_wrap: assert property (@(posedge clk) disable iff (!por_n)
        step && !ld_frac && frac >= W'(FRAC_MAX) |=> frac == '0);

    // R3: carry from the fraction counter advances seconds
    a_r3_sec_carry: assert property (@(posedge clk) disable iff (!por_n)
        step && !ld_sec && frac >= W'(FRAC_MAX) && sec < W'(SEC_MAX) |=> sec == $past(sec) + 1'b1);

    // R4: 24-hour wrap
    a_r4_hour_wrap24: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
        step && !ld_hour && mode24 && full_low && hour >= W'(HR24_MAX) |=> hour == '0 && irq);

    // R5: the flag is sticky without a clearing write
    a_r5_irq_sticky: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
        irq && !clr_wr |=> irq);

    // R6: a wrap beats a same-cycle clear
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
        step && full_low && mode24 && hour >= W'(HR24_MAX) && clr_wr |=> irq);

    // R7: a load overrides the increment
    a_r7_load_wins: assert property (@(posedge clk) disable iff (!por_n)
        ld_frac |=> frac == $past(wdata));

    // R8: no change without an enabled tick or a write
    a_r8_hold: assert property (@(posedge clk) disable iff (!por_n)
        !step && !wr_en |=> $stable(frac) && $stable(sec) && $stable(hour));
endmodule

bind rtc_tod_chain rtc_tod_chain_chk #(
    .W(W), .AW(AW), .FRAC_MAX(FRAC_MAX), .SEC_MAX(SEC_MAX), .HR24_MAX(HR24_MAX)
) u_chk (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .step(carry[0]),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .frac(cnt[0]), .sec(cnt[1]),
    .min_c(cnt[2]), .hour(cnt[3]), .mode24(mode24), .irq(midnight_irq)
);

// File: tb/rtc_tod_chain_test.sv
// Bench for rtc_tod_chain: a vector table walked by one loop, then directed tests.
module rtc_tod_chain_test;
    logic       clk = 0, por_n = 0, warm_rst_n = 1, tick_128 = 0, wr_en = 0;
    logic [2:0] addr = 0;
    logic [7:0] wdata = 0, rdata;
    logic       midnight_irq;
    int         n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    rtc_tod_chain uut (.clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .tick_128(tick_128),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .midnight_irq(midnight_irq));

    // Fields: mode24, frac, sec, min, hour, ticks | exp frac, sec, min, hour, irq
    localparam logic [7:0] VEC [10][11] = '{
        '{0,   0,  0,  0,   0,   1,   1,  0,  0,  0, 0},  // R2 step
        '{0, 127,  0,  0,   0,   1,   0,  1,  0,  0, 0},  // R2 wrap
        '{0, 127, 59,  0,   0,   1,   0,  0,  1,  0, 0},  // R3
        '{0, 127, 59, 59,   5,   1,   0,  0,  0,  6, 0},  // R3
        '{1, 127, 59, 59,  23,   1,   0,  0,  0,  0, 1},  // R4 24h
        '{0, 127, 59, 59,  23,   1,   0,  0,  0, 24, 0},  // R4 256h
        '{0, 127, 59, 59, 255,   1,   0,  0,  0,  0, 1},  // R4 256h wrap
        '{1, 120, 58, 59,  23,  10,   2, 59, 59, 23, 0},  // R2 multi
        '{0, 100,  0,  0,   0, 200,  44,  2,  0,  0, 0},  // R2 long run
        '{1, 127, 59, 59,  30,   1,   0,  0,  0,  0, 1}   // R4 out-of-range hour
    };

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick_128 = 1;
        repeat (n) @(negedge clk);
        tick_128 = 0;
    endtask

    task automatic load_time(input logic [7:0] f, s, m, h);
        wr(1, f); wr(2, s); wr(3, m); wr(4, h);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        por_n = 1;
        // R1 reset state
        rd(0, d); chk("R1 ctrl", d, 8'h01);
        for (int a = 1; a <= 4; a++) begin rd(3'(a), d); chk("R1 counter", d, 0); end
        chk("R1 irq", 8'(midnight_irq), 0);
        // R10 unused address
        rd(7, d); chk("R10 unused", d, 0);

        for (int i = 0; i < 10; i++) begin
            wr(0, {6'b0, VEC[i][0][0], 1'b1});
            load_time(VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]);
            ticks(int'(VEC[i][5]));
            rd(1, d); chk("R2 frac", d, VEC[i][6]);
            rd(2, d); chk("R3 sec", d, VEC[i][7]);
            rd(3, d); chk("R3 min", d, VEC[i][8]);
            rd(4, d); chk("R4 hour", d, VEC[i][9]);
            chk("R5 irq", 8'(midnight_irq), VEC[i][10]);
        end

        // R5 sticky across more ticks, ignored set-write, then clear
        ticks(3); chk("R5 sticky", 8'(midnight_irq), 1);
        wr(0, 8'h03); chk("R5 clear", 8'(midnight_irq), 0);
        wr(0, 8'h07); rd(0, d); chk("R5 set-write ignored", d, 8'h03);

        // R6 clear and wrap in the same cycle
        load_time(127, 59, 59, 23);
        @(negedge clk); tick_128 = 1; wr_en = 1; addr = 0; wdata = 8'h03;
        @(negedge clk); tick_128 = 0; wr_en = 0;
        chk("R6 set wins", 8'(midnight_irq), 1);

        // R7 load beats increment
        wr(1, 5);
        @(negedge clk); tick_128 = 1; wr_en = 1; addr = 1; wdata = 50;
        @(negedge clk); tick_128 = 0; wr_en = 0;
        rd(1, d); chk("R7 load wins", d, 50);

        // R8 disabled: ticks do nothing (flag still set, keep with bit2=1)
        load_time(9, 33, 12, 17);
        wr(0, 8'h06);
        ticks(5);
        rd(1, d); chk("R8 frozen", d, 9);
        rd(0, d); chk("R8 ctrl", d, 8'h06);

        // R9 warm reset keeps time and mode
        @(negedge clk); warm_rst_n = 0;
        repeat (2) @(negedge clk); warm_rst_n = 1;
        rd(0, d); chk("R9 ctrl", d, 8'h03);
        rd(2, d); chk("R9 sec kept", d, 33);
        rd(4, d); chk("R9 hour kept", d, 17);

        // R1 power-on reset clears all
        @(negedge clk); por_n = 0;
        repeat (2) @(negedge clk); por_n = 1;
        rd(0, d); chk("R1 ctrl after POR", d, 8'h01);
        rd(2, d); chk("R1 sec after POR", d, 0);
        rd(4, d); chk("R1 hour after POR", d, 0);

        finish_run();
    end
endmodule